// File: doc/BRIEF.md
# Level-Sensitive Legacy Interrupt Aggregator

This block produces the single level-sensitive legacy interrupt line of a storage controller that serves up to 64 completion queues. It holds one pending flag per queue. The controller's completion logic reports each post to a queue. The controller's doorbell logic reports each head-doorbell write, and says whether that write left the queue's head equal to its tail. From the pending flags and a software mask, the block computes a line that stays high for as long as any unmasked queue has unread completions. The line is not a one-cycle pulse.

Software changes the mask through two write-only actions. One write sets mask bits and the other clears them, each at its own register offset. Reading either offset returns the current mask. When the controller runs in message-signalled mode, the line is frozen and the pending flags are left alone. In that mode each completion post on an enabled queue instead produces a one-cycle notify strobe that carries the vector supplied with the post. Queues whose interrupt-enable flag is clear are ignored in both modes.

Top module: `legacy_irq_agg`

## Requirements
- R1: While reset (`rst_n` low) is applied, and immediately after it, `irq_pin` and `msg_fire` are 0, all pending flags are 0 and the mask reads 0.
- R2: In pin mode, a post (`post_valid`) to an enabled queue `post_qid` sets that queue's pending flag. If the flag is unmasked, `irq_pin` is 1 from the clock after the post.
- R3: In pin mode, a doorbell (`db_valid`) for enabled queue `db_qid` with `db_empty`=1 clears that queue's pending flag. A doorbell with `db_empty`=0 changes nothing. `irq_pin` follows one clock later.
- R4: `irq_pin` is 1 exactly when some pending flag with queue index below 32 has mask bit 0 at the same index, or when any pending flag with index 32 to 63 is set. Flags 32 to 63 have no mask bit.
- R5: A write (`reg_wr`) to offset 0x0C ORs `reg_wdata` into the 32-bit mask.
- R6: A write to offset 0x10 clears each mask bit where `reg_wdata` holds a 1.
- R7: `reg_rdata` shows the current mask whenever `reg_addr` is 0x0C or 0x10, and shows 0 for any other offset.
- R8: `irq_pin` is registered. After any mask write or pending-flag change in pin mode, it takes its new level on the following clock edge.
- R9: While `msg_mode`=1, `irq_pin` holds its value and pending flags are unchanged by posts and doorbells. A post to an enabled queue gives `msg_fire`=1 for one clock, with `msg_vec` equal to `post_vec`, on the clock after the post.
- R10: A post or doorbell aimed at a queue whose `q_irq_en` bit is 0 neither sets nor clears its pending flag, and produces no `msg_fire`.
- R11: If a post and an emptying doorbell hit the same enabled queue in the same cycle, the pending flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_mode | input | 1 | 1 selects message-signalled notification, 0 selects the level line |
| q_irq_en | input | 64 | Per-queue interrupt enable |
| post_valid | input | 1 | Completions were posted to a queue this cycle |
| post_qid | input | 6 | Queue of the post |
| post_vec | input | 11 | Vector number of the posted queue |
| db_valid | input | 1 | A head doorbell was written this cycle |
| db_qid | input | 6 | Queue of the doorbell |
| db_empty | input | 1 | The doorbell left head equal to tail |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Current mask at offsets 0x0C/0x10, otherwise 0 |
| irq_pin | output | 1 | Level interrupt line |
| msg_fire | output | 1 | One-clock message notify strobe |
| msg_vec | output | 11 | Vector carried with `msg_fire` |

## Verification
A wrong pending flag can be seen only through the line. It shows one clock after the next mask change that uncovers it, or it shows as a line that fails to drop after the queue's emptying doorbell. The bench therefore opens and closes mask bits around single pending queues, so that a lost or stuck flag changes `irq_pin` within one cycle. A corrupted mask is visible at once on `reg_rdata`, and also in the line after the next post. In message mode, a mistake that touches the flags stays hidden until the mode returns to pin. For that reason the bench switches back and checks the line in the first pin-mode cycle.

// File: rtl/legacy_irq_agg.sv
module legacy_irq_agg #(
  parameter int NQ = 64,
  parameter int MW = 32,
  parameter int AW = 8,
  parameter int VW = 11,
  parameter logic [AW-1:0] OFS_MSET = 8'h0C,
  parameter logic [AW-1:0] OFS_MCLR = 8'h10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   msg_mode,
  input  logic [NQ-1:0]          q_irq_en,
  input  logic                   post_valid,
  input  logic [$clog2(NQ)-1:0]  post_qid,
  input  logic [VW-1:0]          post_vec,
  input  logic                   db_valid,
  input  logic [$clog2(NQ)-1:0]  db_qid,
  input  logic                   db_empty,
  input  logic                   reg_wr,
  input  logic [AW-1:0]          reg_addr,
  input  logic [MW-1:0]          reg_wdata,
  output logic [MW-1:0]          reg_rdata,
  output logic                   irq_pin,
  output logic                   msg_fire,
  output logic [VW-1:0]          msg_vec
);
  localparam int QW = $clog2(NQ);

  logic [NQ-1:0] pend, pend_nx, set_vec, clr_vec, mask_ext_nx;
  logic [MW-1:0] mask, mask_nx;
  logic post_ok, db_ok, pin_nx;

  assign post_ok = post_valid && (int'(post_qid) < NQ) && q_irq_en[post_qid];
  assign db_ok   = db_valid && db_empty && (int'(db_qid) < NQ) && q_irq_en[db_qid];

  always_comb begin
    set_vec = '0;
    clr_vec = '0;
    if (!msg_mode && post_ok) set_vec[post_qid] = 1'b1;
    if (!msg_mode && db_ok)   clr_vec[db_qid]   = 1'b1;
  end

  assign pend_nx = (pend & ~clr_vec) | set_vec;

  always_comb begin
    mask_nx = mask;
    if (reg_wr && reg_addr == OFS_MSET) mask_nx = mask | reg_wdata;
    if (reg_wr && reg_addr == OFS_MCLR) mask_nx = mask & ~reg_wdata;
  end

  generate
    if (NQ > MW) begin : g_wide
      assign mask_ext_nx = {{(NQ-MW){1'b0}}, mask_nx};
    end else begin : g_narrow
      assign mask_ext_nx = mask_nx[NQ-1:0];
    end
  endgenerate

  assign pin_nx = |(pend_nx & ~mask_ext_nx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= '0;
      mask     <= '0;
      irq_pin  <= 1'b0;
      msg_fire <= 1'b0;
      msg_vec  <= '0;
    end else begin
      pend     <= pend_nx;
      mask     <= mask_nx;
      if (!msg_mode) irq_pin <= pin_nx;
      msg_fire <= msg_mode && post_ok;
      if (msg_mode && post_ok) msg_vec <= post_vec;
    end
  end

  assign reg_rdata = (reg_addr == OFS_MSET || reg_addr == OFS_MCLR) ? mask : '0;

  AST_MASK_SET_OR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_MSET) |=> ((mask & $past(reg_wdata)) == $past(reg_wdata))); // R5
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_MCLR) |=> ((mask & $past(reg_wdata)) == '0)); // R6
  AST_MSG_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    msg_mode |=> $stable(irq_pin)); // R9
  AST_FIRE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_fire |-> $past(post_valid && msg_mode)); // R9
  AST_PIN_RISE_PIN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pin) |-> $past(!msg_mode)); // R8
  AST_DISABLED_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!msg_mode && $past(!msg_mode) && !reg_wr && !db_valid && post_valid
     && !q_irq_en[post_qid]) |=> $stable(irq_pin)); // R10
endmodule

// File: tb/legacy_irq_agg_test.sv
module legacy_irq_agg_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, msg_mode, post_valid, db_valid, db_empty, reg_wr;
  logic [63:0] q_irq_en;
  logic [5:0] post_qid, db_qid;
  logic [10:0] post_vec;
  logic [7:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic irq_pin, msg_fire;
  logic [10:0] msg_vec;

  legacy_irq_agg uut (
    .clk(clk), .rst_n(rst_n), .msg_mode(msg_mode), .q_irq_en(q_irq_en),
    .post_valid(post_valid), .post_qid(post_qid), .post_vec(post_vec),
    .db_valid(db_valid), .db_qid(db_qid), .db_empty(db_empty),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_pin(irq_pin), .msg_fire(msg_fire), .msg_vec(msg_vec)
  );

  typedef struct {
    logic pin; logic fire; logic [10:0] vec; logic [31:0] rd; string tag;
  } exp_t;
  exp_t sb[$];

  int checks = 0, fails = 0;
  logic [63:0] m_pend = '0;
  logic [31:0] m_mask = '0;
  logic m_pin = 1'b0;

  task automatic step(input logic pv, input int pq, input int vec,
                      input logic dv, input int dq, input logic de,
                      input logic wr, input int addr, input logic [31:0] wd,
                      input logic msg, input string tag);
    exp_t e;
    @(negedge clk);
    post_valid = pv; post_qid = 6'(pq); post_vec = 11'(vec);
    db_valid = dv; db_qid = 6'(dq); db_empty = de;
    reg_wr = wr; reg_addr = 8'(addr); reg_wdata = wd; msg_mode = msg;
    if (!msg) begin
      if (dv && de && q_irq_en[dq]) m_pend[dq] = 1'b0;
      if (pv && q_irq_en[pq]) m_pend[pq] = 1'b1;
    end
    if (wr && addr == 'h0C) m_mask = m_mask | wd;
    if (wr && addr == 'h10) m_mask = m_mask & ~wd;
    if (!msg) m_pin = |(m_pend & ~{32'h0, m_mask});
    e.pin = m_pin;
    e.fire = msg && pv && q_irq_en[pq];
    e.vec = 11'(vec);
    e.rd = (addr == 'h0C || addr == 'h10) ? m_mask : 32'h0;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input int addr, input string tag);
    step(0, 0, 0, 0, 0, 0, 0, addr, 0, 0, tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (irq_pin !== e.pin || msg_fire !== e.fire || reg_rdata !== e.rd ||
          (e.fire && msg_vec !== e.vec)) begin
        fails++;
        $display("FAIL %s: pin=%b fire=%b vec=%0d rd=%h expected pin=%b fire=%b vec=%0d rd=%h",
                 e.tag, irq_pin, msg_fire, msg_vec, reg_rdata, e.pin, e.fire, e.vec, e.rd);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; msg_mode = 0; q_irq_en = '1; q_irq_en[5] = 1'b0;
    post_valid = 0; post_qid = 0; post_vec = 0; db_valid = 0; db_qid = 0;
    db_empty = 0; reg_wr = 0; reg_addr = 8'h0C; reg_wdata = 0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (irq_pin !== 0 || msg_fire !== 0 || reg_rdata !== 0) begin
      fails++;
      $display("FAIL R1: pin=%b fire=%b rd=%h expected 0 0 0", irq_pin, msg_fire, reg_rdata);
    end
    @(negedge clk); rst_n = 1;

    idle('h0C, "R1");
    step(1, 3, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    idle(0, "R2");
    step(0, 0, 0, 1, 3, 0, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 1, 3, 1, 0, 0, 0, 0, "R3");
    step(1, 40, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 0, 1, 'h0C, 32'hFFFF_FFFF, 0, "R5");
    step(0, 0, 0, 1, 40, 1, 0, 'h0C, 0, 0, "R4");
    step(1, 3, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 0, 1, 'h10, 32'h8, 0, "R6");
    idle('h10, "R7");
    idle('h14, "R7");
    step(0, 0, 0, 0, 0, 0, 1, 'h0C, 32'h8, 0, "R8");
    step(0, 0, 0, 0, 0, 0, 1, 'h10, 32'hFFFF_FFFF, 0, "R8");
    step(0, 0, 0, 1, 3, 1, 0, 'h0C, 0, 0, "R3");
    step(1, 5, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
    @(negedge clk); q_irq_en[5] = 1'b1;
    step(1, 5, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    @(negedge clk); q_irq_en[5] = 1'b0;
    step(0, 0, 0, 1, 5, 1, 0, 0, 0, 0, "R10");
    @(negedge clk); q_irq_en[5] = 1'b1;
    step(0, 0, 0, 1, 5, 1, 0, 0, 0, 0, "R3");
    step(1, 7, 0, 1, 7, 1, 0, 0, 0, 0, "R11");
    step(0, 0, 0, 1, 7, 1, 0, 0, 0, 0, "R3");
    step(1, 9, 17, 0, 0, 0, 0, 0, 0, 1, "R9");
    idle(0, "R9");
    step(1, 2, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 1, 2, 1, 0, 0, 0, 1, "R9");
    step(1, 33, 1234, 0, 0, 0, 0, 0, 0, 1, "R9");
    idle(0, "R9");
    @(negedge clk); q_irq_en[5] = 1'b0;
    step(1, 5, 99, 0, 0, 0, 0, 0, 0, 1, "R10");
    step(0, 0, 0, 1, 2, 1, 0, 0, 0, 0, "R3");
    idle(0, "R4");

    @(posedge clk); #2;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule